// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timing Generator

This block produces the strobe waveform of one bus cycle at a time on an 8-bit NAND flash interface. A host asks for a cycle through a request/acknowledge port and gives the cycle kind and the write byte. The block then drives the latch-enable lines, the write or read strobe and the data output enable through three timed phases. A setup phase holds the command or address latch enable before the strobe. A strobe phase follows. A hold phase keeps the bus stable after the strobe returns high. Each phase length comes from its own 3-bit timing input, counted in system clocks, and the three inputs follow different offset rules.

The chip-enable output follows a configuration bit. A global enable input stops new cycles from starting. The ready/busy line from the flash passes through a two-stage synchroniser into an edge detector. The edge it looks for can be selected. A detected edge sets a sticky flag, which stays set until a one-cycle clear pulse arrives, the same effect as a write-1-to-clear status bit.

Top module: `nand_strobe_gen`

## Requirements
- R1: After a request is accepted, the setup phase lasts `cfg_setup` clocks before the strobe goes low. When `cfg_setup` is 0 the setup phase is skipped, and the strobe is low in the first clock after acceptance.
- R2: The strobe (`nand_we_n` or `nand_re_n`) stays low for exactly `cfg_strobe`+1 consecutive clocks.
- R3: The hold phase lasts `cfg_hold`+1 clocks after the strobe rises. `req_ack` is then high for exactly one clock, and in the clock after that the bus is back at its idle levels.
- R4: The `req_kind` encoding is as follows. 0 is a command cycle (`nand_cle` high). 1 is an address cycle (`nand_ale` high). 2 is a data write. 3 is a data read. Kinds 0 to 2 pulse `nand_we_n`, and kind 3 pulses `nand_re_n`; the other strobe stays high. For kinds 0 and 1 the latch enable is high through the setup, strobe and hold phases, and for kinds 2 and 3 both latch enables stay low.
- R5: For kinds 0 to 2, `nand_dq_oe` is high and `nand_dq_o` carries `req_wdata` from acceptance until ack.
- R6: On a read, `req_rdata` takes the value of `nand_dq_i` present in the last clock of the strobe phase, and it holds that value afterwards.
- R7: While `cfg_enable` is 0, no cycle starts, even with `req_valid` held high. A pending request starts once `cfg_enable` rises.
- R8: A request still high in the clock in which `req_ack` is high is ignored. A new cycle needs `req_valid` high in a later clock.
- R9: `nand_ce_n` takes the value of `cfg_ce_n` one clock later (0 selects the device).
- R10: `cfg_rb_fall`=0 detects low-to-high transitions of `nand_rb`, and 1 detects high-to-low. The non-selected edge never sets the flag. After a selected transition, `rb_flag` is high by the third rising clock edge.
- R11: `rb_flag` stays set until a one-clock pulse on `rb_clr`, and it is low in the clock after that pulse.
- R12: After reset, `nand_cle`=`nand_ale`=0, `nand_we_n`=`nand_re_n`=1, `nand_dq_oe`=0, `req_ack`=0, `rb_flag`=0 and `nand_ce_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Allows new bus cycles to start |
| cfg_ce_n | input | 1 | Chip-enable level, 0 selects the device |
| cfg_setup | input | 3 | Setup phase length in clocks |
| cfg_strobe | input | 3 | Strobe phase length minus one |
| cfg_hold | input | 3 | Hold phase length minus one |
| cfg_rb_fall | input | 1 | Ready/busy edge select, 1 = falling |
| rb_clr | input | 1 | Clears the ready/busy flag |
| req_valid | input | 1 | Cycle request |
| req_kind | input | 2 | Cycle kind (see R4) |
| req_wdata | input | 8 | Byte driven in command, address or write cycles |
| req_ack | output | 1 | One-clock completion pulse |
| req_rdata | output | 8 | Byte captured by the last read |
| rb_flag | output | 1 | Sticky ready/busy edge flag |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_dq_o | output | 8 | Data bus output |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus input |
| nand_rb | input | 1 | Ready/busy line from the device |

## Verification
The bench numbers the clocks of each cycle from the first falling edge after acceptance. Under that numbering the strobe is due low in clock `cfg_setup`+1 and stays low for `cfg_strobe`+1 clocks, and ack is due in clock `cfg_setup`+`cfg_strobe`+`cfg_hold`+3. The bench compares the measured clock numbers with these figures. It changes `nand_dq_i` every clock, so the captured read byte shows exactly which clock was sampled. Ready/busy checks are made at the second and third falling edges after the line changes, which brackets the two synchroniser stages and the flag register. The chip-enable check is made one edge after the configuration bit changes.

// File: rtl/nsg_pkg.sv
package nsg_pkg;

    typedef enum logic [1:0] {
        KIND_CMD   = 2'd0,
        KIND_ADDR  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_READ  = 2'd3
    } bus_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

endpackage

// File: rtl/nsg_phase_seq.sv
module nsg_phase_seq
    import nsg_pkg::*;
#(
    parameter int DW = 8,
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [TW-1:0] setup_len,
    input  logic [TW-1:0] strobe_len,
    input  logic [TW-1:0] hold_len,
    input  logic          req_valid,
    input  bus_kind_e     req_kind,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ack,
    output logic [DW-1:0] req_rdata,
    output logic          cle,
    output logic          ale,
    output logic          we_n,
    output logic          re_n,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe,
    input  logic [DW-1:0] dq_i
);

    localparam logic [TW-1:0] ONE = TW'(1);

    typedef struct packed {
        phase_e        ph;
        logic [TW-1:0] cnt;
        bus_kind_e     kind;
        logic [DW-1:0] wdata;
        logic [TW-1:0] strobe_cnt;
        logic [TW-1:0] hold_cnt;
        logic [DW-1:0] rdata;
        logic          ack;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (enable && req_valid && !q.ack) begin
                    d.kind       = req_kind;
                    d.wdata      = req_wdata;
                    d.strobe_cnt = strobe_len;
                    d.hold_cnt   = hold_len;
                    if (setup_len != '0) begin
                        d.ph  = PH_SETUP;
                        d.cnt = setup_len - ONE;
                    end else begin
                        d.ph  = PH_STROBE;
                        d.cnt = strobe_len;
                    end
                end
            end
            PH_SETUP: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_STROBE;
                    d.cnt = q.strobe_cnt;
                end else begin
                    d.cnt = q.cnt - ONE;
                end
            end
            PH_STROBE: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_HOLD;
                    d.cnt = q.hold_cnt;
                    if (q.kind == KIND_READ) d.rdata = dq_i;
                end else begin
                    d.cnt = q.cnt - ONE;
                end
            end
            PH_HOLD: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_IDLE;
                    d.ack = 1'b1;
                end else begin
                    d.cnt = q.cnt - ONE;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic active;
    assign active    = (q.ph != PH_IDLE);
    assign cle       = active && (q.kind == KIND_CMD);
    assign ale       = active && (q.kind == KIND_ADDR);
    assign we_n      = !((q.ph == PH_STROBE) && (q.kind != KIND_READ));
    assign re_n      = !((q.ph == PH_STROBE) && (q.kind == KIND_READ));
    assign dq_oe     = active && (q.kind != KIND_READ);
    assign dq_o      = q.wdata;
    assign req_ack   = q.ack;
    assign req_rdata = q.rdata;

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    assert_one_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    assert_ack_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    assert_strobe_to_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_STROBE && q.cnt == '0) |=> (q.ph == PH_HOLD && we_n && re_n));

    assert_no_start_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_IDLE && !enable) |=> (q.ph == PH_IDLE));

    assert_ack_blocks_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> (q.ph == PH_IDLE));

endmodule

// File: rtl/nsg_rb_edge.sv
module nsg_rb_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_async,
    input  logic fall_sel,
    input  logic clr,
    output logic flag
);

    localparam int SW = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SW-1:0] sh;
        logic          flag;
    } rb_t;

    rb_t  q, d;
    logic cur, prev, hit;

    assign cur  = q.sh[SYNC_STAGES-1];
    assign prev = q.sh[SYNC_STAGES];
    assign hit  = fall_sel ? (prev && !cur) : (!prev && cur);

    always_comb begin
        d      = q;
        d.sh   = {q.sh[SW-2:0], rb_async};
        d.flag = hit ? 1'b1 : (clr ? 1'b0 : q.flag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sh   <= '1;
            q.flag <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign flag = q.flag;

    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !flag);

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
    import nsg_pkg::*;
#(
    parameter int DW          = 8,
    parameter int TW          = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_enable,
    input  logic          cfg_ce_n,
    input  logic [TW-1:0] cfg_setup,
    input  logic [TW-1:0] cfg_strobe,
    input  logic [TW-1:0] cfg_hold,
    input  logic          cfg_rb_fall,
    input  logic          rb_clr,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ack,
    output logic [DW-1:0] req_rdata,
    output logic          rb_flag,
    output logic          nand_cle,
    output logic          nand_ale,
    output logic          nand_we_n,
    output logic          nand_re_n,
    output logic          nand_ce_n,
    output logic [DW-1:0] nand_dq_o,
    output logic          nand_dq_oe,
    input  logic [DW-1:0] nand_dq_i,
    input  logic          nand_rb
);

    logic ce_d, ce_q;

    always_comb ce_d = cfg_ce_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ce_q <= 1'b1;
        else        ce_q <= ce_d;
    end

    assign nand_ce_n = ce_q;

    nsg_phase_seq #(.DW(DW), .TW(TW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg_enable),
        .setup_len  (cfg_setup),
        .strobe_len (cfg_strobe),
        .hold_len   (cfg_hold),
        .req_valid  (req_valid),
        .req_kind   (bus_kind_e'(req_kind)),
        .req_wdata  (req_wdata),
        .req_ack    (req_ack),
        .req_rdata  (req_rdata),
        .cle        (nand_cle),
        .ale        (nand_ale),
        .we_n       (nand_we_n),
        .re_n       (nand_re_n),
        .dq_o       (nand_dq_o),
        .dq_oe      (nand_dq_oe),
        .dq_i       (nand_dq_i)
    );

    nsg_rb_edge #(.SYNC_STAGES(SYNC_STAGES)) u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_async (nand_rb),
        .fall_sel (cfg_rb_fall),
        .clr      (rb_clr),
        .flag     (rb_flag)
    );

    assert_ce_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_ce_n) == nand_ce_n || $rose(rst_n));

endmodule

// File: tb/nand_strobe_gen_bench.sv
`timescale 1ns/1ps
module nand_strobe_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b0, cfg_ce_n = 1'b1, cfg_rb_fall = 1'b0, rb_clr = 1'b0;
    logic [2:0] cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = '0;
    logic [7:0] req_wdata = '0, nand_dq_i = '0;
    logic       nand_rb = 1'b1;
    logic       req_ack, rb_flag, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_ce_n, nand_dq_oe;
    logic [7:0] req_rdata, nand_dq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    nand_strobe_gen u_nand_strobe_gen (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_ce_n(cfg_ce_n),
        .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
        .cfg_rb_fall(cfg_rb_fall), .rb_clr(rb_clr), .req_valid(req_valid),
        .req_kind(req_kind), .req_wdata(req_wdata), .req_ack(req_ack),
        .req_rdata(req_rdata), .rb_flag(rb_flag), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_ce_n(nand_ce_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
        .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
    );

    // {kind[18:17], setup[16:14], strobe[13:11], hold[10:8], byte[7:0]}
    localparam logic [18:0] VEC [8] = '{
        {2'd0, 3'd1, 3'd0, 3'd0, 8'h70},
        {2'd1, 3'd0, 3'd2, 3'd1, 8'h5A},
        {2'd2, 3'd3, 3'd3, 3'd2, 8'hC3},
        {2'd3, 3'd2, 3'd1, 3'd0, 8'h00},
        {2'd3, 3'd0, 3'd0, 3'd3, 8'h00},
        {2'd2, 3'd7, 3'd7, 3'd7, 8'hFF},
        {2'd0, 3'd0, 3'd0, 3'd0, 8'h00},
        {2'd3, 3'd7, 3'd5, 3'd1, 8'h00}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic [1:0] kind, input logic [2:0] ts,
                             input logic [2:0] tw0, input logic [2:0] tw1,
                             input logic [7:0] data);
        int first_low = 0, low_cnt = 0, ack_at = 0, sel_cnt = 0, oe_bad = 0, other_bad = 0;
        int exp_ack, sel_exp;
        @(negedge clk);
        cfg_setup = ts; cfg_strobe = tw0; cfg_hold = tw1;
        req_kind = kind; req_wdata = data; req_valid = 1'b1;
        nand_dq_i = 8'hA0;
        for (int n = 1; n < 60; n++) begin
            @(negedge clk);
            if (req_ack) begin
                ack_at = n;
                req_valid = 1'b0;
                break;
            end
            if ((kind == 2'd3) ? !nand_re_n : !nand_we_n) begin
                if (first_low == 0) first_low = n;
                low_cnt++;
            end
            if ((kind == 2'd3) ? !nand_we_n : !nand_re_n) other_bad++;
            if (kind == 2'd0 && nand_cle && !nand_ale) sel_cnt++;
            if (kind == 2'd1 && nand_ale && !nand_cle) sel_cnt++;
            if (kind[1] && (nand_ale || nand_cle)) other_bad++;
            if (kind != 2'd3 && !(nand_dq_oe && nand_dq_o == data)) oe_bad++;
            if (kind == 2'd3 && nand_dq_oe) oe_bad++;
            nand_dq_i = 8'(8'hA0 + n);
        end
        exp_ack = int'(ts) + int'(tw0) + int'(tw1) + 3;
        sel_exp = (kind[1]) ? 0 : exp_ack - 1;
        check(first_low == int'(ts) + 1, "R1 strobe start clock", first_low, int'(ts) + 1);
        check(low_cnt == int'(tw0) + 1, "R2 strobe length", low_cnt, int'(tw0) + 1);
        check(ack_at == exp_ack, "R3 ack clock", ack_at, exp_ack);
        check(sel_cnt == sel_exp && other_bad == 0, "R4 latch/strobe kind", sel_cnt, sel_exp);
        check(oe_bad == 0, "R5 data drive", oe_bad, 0);
        if (kind == 2'd3)
            check(req_rdata == 8'(8'hA0 + int'(ts) + int'(tw0) + 1), "R6 read capture",
                  int'(req_rdata), int'(8'(8'hA0 + int'(ts) + int'(tw0) + 1)));
        @(negedge clk);
        check(!req_ack && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe,
              "R3 single ack and idle bus", int'(req_ack), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset levels
        check(!nand_cle && !nand_ale && nand_we_n && nand_re_n && !nand_dq_oe && !req_ack
              && !rb_flag && nand_ce_n, "R12 reset levels", int'(nand_we_n), 1);

        // R7: disabled controller ignores a held request
        req_kind = 2'd0; req_wdata = 8'hFF; req_valid = 1'b1;
        seen = 0;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (!nand_we_n || nand_cle || req_ack) seen++;
        end
        check(seen == 0, "R7 no cycle while disabled", seen, 0);
        cfg_enable = 1'b1;
        seen = 0;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            if (req_ack) begin seen = 1; break; end
        end
        check(seen == 1, "R7 pending request starts when enabled", seen, 1);
        // R8: request still high during the ack clock
        @(negedge clk);
        req_valid = 1'b0;
        seen = 0;
        for (int n = 0; n < 15; n++) begin
            @(negedge clk);
            if (!nand_we_n || nand_cle || req_ack) seen++;
        end
        check(seen == 0, "R8 request in ack clock ignored", seen, 0);

        // Table of cycles
        for (int i = 0; i < 8; i++)
            bus_cycle(VEC[i][18:17], VEC[i][16:14], VEC[i][13:11], VEC[i][10:8], VEC[i][7:0]);

        // R9 chip enable follows one clock later
        @(negedge clk);
        cfg_ce_n = 1'b0;
        #1;
        check(nand_ce_n == 1'b1, "R9 ce before edge", int'(nand_ce_n), 1);
        @(negedge clk);
        check(nand_ce_n == 1'b0, "R9 ce selected", int'(nand_ce_n), 0);
        cfg_ce_n = 1'b1;
        @(negedge clk);
        check(nand_ce_n == 1'b1, "R9 ce deselected", int'(nand_ce_n), 1);

        // R10 rising edge mode: falling transition must not set
        cfg_rb_fall = 1'b0;
        nand_rb = 1'b0;
        repeat (6) @(negedge clk);
        check(rb_flag == 1'b0, "R10 falling ignored in rising mode", int'(rb_flag), 0);
        nand_rb = 1'b1;
        repeat (2) @(negedge clk);
        check(rb_flag == 1'b0, "R10 flag not before third edge", int'(rb_flag), 0);
        @(negedge clk);
        check(rb_flag == 1'b1, "R10 rising edge sets flag", int'(rb_flag), 1);
        // R11 sticky, then cleared
        repeat (10) @(negedge clk);
        check(rb_flag == 1'b1, "R11 flag sticky", int'(rb_flag), 1);
        rb_clr = 1'b1;
        @(negedge clk);
        rb_clr = 1'b0;
        check(rb_flag == 1'b0, "R11 clear pulse", int'(rb_flag), 0);

        // R10 falling edge mode
        cfg_rb_fall = 1'b1;
        repeat (4) @(negedge clk);
        check(rb_flag == 1'b0, "R10 mode change alone no set", int'(rb_flag), 0);
        nand_rb = 1'b0;
        repeat (3) @(negedge clk);
        check(rb_flag == 1'b1, "R10 falling edge sets flag", int'(rb_flag), 1);
        rb_clr = 1'b1;
        @(negedge clk);
        rb_clr = 1'b0;
        nand_rb = 1'b1;
        repeat (6) @(negedge clk);
        check(rb_flag == 1'b0, "R10 rising ignored in falling mode", int'(rb_flag), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule